// File: doc/BRIEF.md
# Memory Operation Queue with Address Disambiguation

This block holds loads and stores between the issue stage and one shared, multi-cycle memory port. Each operation arrives with its effective address already computed. A store's data either comes with it or is picked up later from the result broadcast bus, by matching the tag of the operation that produces it. A load issued into the queue is compared at once against every older store still held. With no address match, it can go to memory ahead of those stores. With a match, it takes its value from the youngest matching store and never reads memory.

A store whose address equals that of an older store still waiting in the queue replaces that store. The older store is dropped and never written. Only one memory request is in flight at a time. Loads win the port over stores. Load results leave on a registered result port as tag plus value, one per cycle. A memory return wins over a forwarded value in the same cycle.

The queue is kept in age order: entry 0 is the oldest, and entries close up as they leave. Age therefore equals position. A full queue lowers `iss_ready` and issue stalls.

Top module: `ldst_queue`

## Requirements
- R1: `iss_ready` is high exactly when fewer than DEPTH operations are held. An operation offered with `iss_valid` while `iss_ready` is high is accepted at that clock edge.
- R2: With `iss_data_ok`=1 a store takes `iss_data`. Otherwise it captures `bc_data` in the first cycle with `bc_valid`=1 and `bc_tag` equal to its `iss_src_tag`, and this includes the issue cycle. A store is never sent to memory before its data is held.
- R3: A load (`iss_store`=0) whose address matches no older held store is sent to memory, even while older stores are still waiting for data.
- R4: A load whose address matches one or more older held stores returns the data of the youngest of them and never reads memory. If that data is already held, `res_valid` rises one cycle after the edge that accepts the load.
- R5: If that youngest matching store has no data yet, the load waits. It returns the value captured from the broadcast with that store's data tag, without a memory read.
- R6: A store accepted with the same address as an older held store that has not yet been sent to memory removes the older store, which is never written.
- R7: When the port is free and a load and a store are both ready, the oldest ready load is sent first. So no store reaches memory ahead of an older load to the same address.
- R8: At most one request is outstanding. `mem_req_valid` (`mem_req_write`=1 for a store) is a single-cycle pulse, and no new request follows until `mem_done` has been seen.
- R9: A load served by memory appears on `res_valid`/`res_tag`/`res_data` with `mem_rdata` in the cycle after the edge that samples `mem_done`. Memory returns win over forwarded results. At most one result is presented per cycle, and every load produces exactly one result.
- R10: After reset the queue is empty, with `iss_ready`=1, `mem_req_valid`=0 and `res_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Operation offered at issue |
| iss_ready | output | 1 | Queue has a free entry |
| iss_store | input | 1 | 1 = store, 0 = load |
| iss_addr | input | AW | Effective address |
| iss_tag | input | TW | Destination tag of a load |
| iss_data_ok | input | 1 | Store data present in iss_data |
| iss_data | input | DW | Store data when present |
| iss_src_tag | input | TW | Producer tag of store data when not present |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TW | Result broadcast tag |
| bc_data | input | DW | Result broadcast value |
| mem_req_valid | output | 1 | One-cycle memory request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_done | input | 1 | Outstanding request completed |
| mem_rdata | input | DW | Read data, valid with mem_done |
| res_valid | output | 1 | Load result valid |
| res_tag | output | TW | Tag of the completing load |
| res_data | output | DW | Load value |

## Verification
A forwarded load with data already held shows its result one cycle after its accept edge. A memory read request appears one edge after the oldest ready load is seen, and the matching result appears at the very edge that samples `mem_done`. The bench drives inputs and samples outputs on the falling edge. It checks the forwarding result at the second falling edge after the accept edge, and the order of memory requests one falling edge after each request edge. Values that depend on when memory happens to be free, such as loads that may either forward or read, are checked by tag when they arrive and by counts after a fixed drain time, never at an exact cycle.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic {OP_LD = 1'b0, OP_ST = 1'b1} op_e;
endpackage

// File: rtl/ldst_oldest.sv
// Picks the lowest-index (oldest) request.
module ldst_oldest #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    gnt = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldst_addr_cam.sv
// Associative address compare across all held entries.
module ldst_addr_cam #(
  parameter int N  = 8,
  parameter int AW = 16
) (
  input  logic [N-1:0]         en,
  input  logic [N-1:0][AW-1:0] keys,
  input  logic [AW-1:0]        probe,
  output logic [N-1:0]         hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = en[g] && (keys[g] == probe);
  end
endmodule

// File: rtl/ldst_onehot_mux.sv
module ldst_onehot_mux #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] din,
  output logic [W-1:0]        dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) dout = dout | din[i];
    end
  end
endmodule

// File: rtl/ldst_queue.sv
module ldst_queue
  import ldst_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int TW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  output logic          iss_ready,
  input  logic          iss_store,
  input  logic [AW-1:0] iss_addr,
  input  logic [TW-1:0] iss_tag,
  input  logic          iss_data_ok,
  input  logic [DW-1:0] iss_data,
  input  logic [TW-1:0] iss_src_tag,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_data,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata,
  output logic          res_valid,
  output logic [TW-1:0] res_tag,
  output logic [DW-1:0] res_data
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam int SW = 1 + TW + DW;   // forward source: dval, dtag, data
  localparam int RW = 1 + AW + DW;   // request: write, addr, data
  localparam int FW = 1 + TW;        // in-flight: is store, tag
  localparam int OW = TW + DW;       // result: tag, data

  typedef struct packed {
    op_e           op;
    logic [AW-1:0] addr;
    logic [TW-1:0] tag;
    logic          dval;
    logic [TW-1:0] dtag;
    logic [DW-1:0] data;
    logic          fwd;
    logic          fly;
  } ent_t;

  ent_t [DEPTH-1:0] q, upd, n_q;
  logic [DEPTH-1:0] qv, n_qv;
  logic             busy;

  logic [CW-1:0] cnt;
  logic          iss_fire;

  logic [DEPTH-1:0]         is_st, cap, ld_req, st_req, fr_req, fly_vec;
  logic [DEPTH-1:0][AW-1:0] addr_v;
  logic [DEPTH-1:0][SW-1:0] src_v;
  logic [DEPTH-1:0][RW-1:0] req_v;
  logic [DEPTH-1:0][FW-1:0] fly_v;
  logic [DEPTH-1:0][OW-1:0] out_v;

  // per-entry views of the held state
  always_comb begin
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt        = cnt + CW'(qv[i]);
      is_st[i]   = qv[i] && (q[i].op == OP_ST);
      cap[i]     = qv[i] && !q[i].dval && ((q[i].op == OP_ST) || q[i].fwd) &&
                   bc_valid && (bc_tag == q[i].dtag);
      ld_req[i]  = qv[i] && (q[i].op == OP_LD) && !q[i].fwd && !q[i].fly;
      st_req[i]  = is_st[i] && q[i].dval && !q[i].fly;
      fr_req[i]  = qv[i] && (q[i].op == OP_LD) && q[i].fwd && q[i].dval;
      fly_vec[i] = qv[i] && q[i].fly;
      addr_v[i]  = q[i].addr;
      src_v[i]   = {q[i].dval | cap[i], q[i].dtag, q[i].dval ? q[i].data : bc_data};
      req_v[i]   = {q[i].op == OP_ST, q[i].addr, q[i].data};
      fly_v[i]   = {q[i].op == OP_ST, q[i].tag};
      out_v[i]   = {q[i].tag, q[i].data};
    end
  end

  assign iss_ready = (cnt < CW'(DEPTH));
  assign iss_fire  = iss_valid && iss_ready;

  // ---------------- disambiguation against older stores ----------------
  logic [DEPTH-1:0] st_hit, st_hit_r, yng_r, yng;
  logic             yng_any;
  logic [SW-1:0]    fsrc;

  ldst_addr_cam #(.N(DEPTH), .AW(AW)) u_cam (
    .en(is_st), .keys(addr_v), .probe(iss_addr), .hit(st_hit)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) st_hit_r[i] = st_hit[DEPTH-1-i];
  end

  ldst_oldest #(.N(DEPTH)) u_youngest (
    .req(st_hit_r), .gnt(yng_r), .any(yng_any)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) yng[i] = yng_r[DEPTH-1-i];
  end

  ldst_onehot_mux #(.N(DEPTH), .W(SW)) u_fsrc (
    .sel(yng), .din(src_v), .dout(fsrc)
  );

  // ---------------- memory port scheduling ----------------
  logic [DEPTH-1:0] ld_gnt, st_gnt, grant, grant_eff;
  logic             ld_any, st_any, send;
  logic [RW-1:0]    req_sel;
  logic [FW-1:0]    fly_sel;

  ldst_oldest #(.N(DEPTH)) u_ld_pick (.req(ld_req), .gnt(ld_gnt), .any(ld_any));
  ldst_oldest #(.N(DEPTH)) u_st_pick (.req(st_req), .gnt(st_gnt), .any(st_any));

  assign grant     = ld_any ? ld_gnt : st_gnt;
  assign send      = !busy && (ld_any || st_any);
  assign grant_eff = send ? grant : '0;

  ldst_onehot_mux #(.N(DEPTH), .W(RW)) u_req_mux (
    .sel(grant_eff), .din(req_v), .dout(req_sel)
  );
  ldst_onehot_mux #(.N(DEPTH), .W(FW)) u_fly_mux (
    .sel(fly_vec), .din(fly_v), .dout(fly_sel)
  );

  // ---------------- result selection ----------------
  logic [DEPTH-1:0] fr_gnt;
  logic             fr_any, mem_ld_done, fwd_out;
  logic [OW-1:0]    fr_sel;

  ldst_oldest #(.N(DEPTH)) u_fr_pick (.req(fr_req), .gnt(fr_gnt), .any(fr_any));
  ldst_onehot_mux #(.N(DEPTH), .W(OW)) u_fr_mux (
    .sel(fr_gnt), .din(out_v), .dout(fr_sel)
  );

  assign mem_ld_done = mem_done && busy && !fly_sel[FW-1];
  assign fwd_out     = fr_any && !mem_ld_done;

  // ---------------- removal, update, new entry ----------------
  logic [DEPTH-1:0] rm;
  ent_t             ne;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rm[i] = (mem_done && fly_vec[i]) ||
              (iss_fire && iss_store && st_hit[i] && !q[i].fly && !grant_eff[i]) ||
              (fwd_out && fr_gnt[i]);
      upd[i] = q[i];
      if (cap[i]) begin
        upd[i].dval = 1'b1;
        upd[i].data = bc_data;
      end
      if (grant_eff[i]) upd[i].fly = 1'b1;
    end
  end

  always_comb begin
    ne      = '0;
    ne.op   = iss_store ? OP_ST : OP_LD;
    ne.addr = iss_addr;
    ne.tag  = iss_tag;
    if (iss_store) begin
      ne.dtag = iss_src_tag;
      if (iss_data_ok) begin
        ne.dval = 1'b1;
        ne.data = iss_data;
      end else if (bc_valid && (bc_tag == iss_src_tag)) begin
        ne.dval = 1'b1;
        ne.data = bc_data;
      end
    end else if (yng_any) begin
      ne.fwd  = 1'b1;
      ne.dval = fsrc[SW-1];
      ne.dtag = fsrc[SW-2 -: TW];
      ne.data = fsrc[DW-1:0];
    end
  end

  // collapse survivors toward entry 0, then append
  always_comb begin
    logic [CW-1:0] k;
    k    = '0;
    n_q  = q;
    n_qv = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (qv[i] && !rm[i]) begin
        n_q[k[IW-1:0]]  = upd[i];
        n_qv[k[IW-1:0]] = 1'b1;
        k = k + CW'(1);
      end
    end
    if (iss_fire) begin
      n_q[k[IW-1:0]]  = ne;
      n_qv[k[IW-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    q <= n_q;
    if (rst) begin
      qv            <= '0;
      busy          <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      res_valid     <= 1'b0;
      res_tag       <= '0;
      res_data      <= '0;
    end else begin
      qv            <= n_qv;
      mem_req_valid <= send;
      if (send) begin
        busy          <= 1'b1;
        mem_req_write <= req_sel[RW-1];
        mem_req_addr  <= req_sel[RW-2 -: AW];
        mem_req_wdata <= req_sel[DW-1:0];
      end else if (mem_done) begin
        busy <= 1'b0;
      end
      if (mem_ld_done) begin
        res_valid <= 1'b1;
        res_tag   <= fly_sel[TW-1:0];
        res_data  <= mem_rdata;
      end else if (fwd_out) begin
        res_valid <= 1'b1;
        res_tag   <= fr_sel[OW-1 -: TW];
        res_data  <= fr_sel[DW-1:0];
      end else begin
        res_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ldst_queue_chk.sv
module ldst_queue_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          iss_ready,
  input logic          mem_req_valid,
  input logic          mem_req_write,
  input logic          mem_done,
  input logic [DW-1:0] mem_rdata,
  input logic          res_valid,
  input logic [DW-1:0] res_data
);
  logic out_q, rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      rd_q  <= 1'b0;
    end else if (mem_req_valid) begin
      out_q <= 1'b1;
      rd_q  <= !mem_req_write;
    end else if (mem_done) begin
      out_q <= 1'b0;
      rd_q  <= 1'b0;
    end
  end

  // R8: no second request while one is outstanding
  p_single_req_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !out_q);

  // R8: requests are one-cycle pulses
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  // R9: a completed read is presented on the next cycle with its data
  p_mem_result_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_done && rd_q) |=> (res_valid && (res_data == $past(mem_rdata))));

  // R10: quiet, empty outputs right after reset
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req_valid && !res_valid && iss_ready));
endmodule

bind ldst_queue ldst_queue_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .iss_ready(iss_ready),
  .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
  .mem_done(mem_done), .mem_rdata(mem_rdata),
  .res_valid(res_valid), .res_data(res_data)
);

// File: tb/ldst_queue_test.sv
module ldst_queue_test;
  localparam int DEPTH = 8;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int LAT = 3;
  localparam int NV = 11;

  // {store, addr[8], load tag[4], data_ok, src tag[4], data[16]}
  localparam logic [33:0] TBL [NV] = '{
    {1'b1, 8'd3, 4'd0, 1'b0, 4'd12, 16'h1111},
    {1'b0, 8'd4, 4'd1, 1'b0, 4'd0,  16'h0000},
    {1'b0, 8'd3, 4'd2, 1'b0, 4'd0,  16'h0000},
    {1'b1, 8'd5, 4'd0, 1'b1, 4'd0,  16'h2222},
    {1'b0, 8'd5, 4'd3, 1'b0, 4'd0,  16'h0000},
    {1'b1, 8'd6, 4'd0, 1'b0, 4'd13, 16'h3333},
    {1'b0, 8'd7, 4'd4, 1'b0, 4'd0,  16'h0000},
    {1'b0, 8'd6, 4'd5, 1'b0, 4'd0,  16'h0000},
    {1'b1, 8'd3, 4'd0, 1'b1, 4'd0,  16'h4444},
    {1'b0, 8'd3, 4'd6, 1'b0, 4'd0,  16'h0000},
    {1'b0, 8'd8, 4'd7, 1'b0, 4'd0,  16'h0000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 1'b0, iss_store = 1'b0, iss_data_ok = 1'b0;
  logic [AW-1:0] iss_addr = '0;
  logic [TW-1:0] iss_tag = '0, iss_src_tag = '0;
  logic [DW-1:0] iss_data = '0;
  logic bc_valid = 1'b0;
  logic [TW-1:0] bc_tag = '0;
  logic [DW-1:0] bc_data = '0;
  logic mem_done = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic iss_ready, mem_req_valid, mem_req_write, res_valid;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata, res_data;
  logic [TW-1:0] res_tag;

  ldst_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) uut (.*);

  always #2 clk = ~clk;

  int ntest = 0, nfail = 0, nreq = 0, nrd = 0, wr3 = 0, overlap = 0;
  logic [DW-1:0] bmem [256];
  logic [AW-1:0] log_addr [64];
  logic          log_wr [64];
  logic [DW-1:0] exp_val [16];
  bit            exp_set [16];
  int            got [16];
  bit            done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] expv);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic issue(input logic st, input logic [7:0] a, input logic [3:0] tg,
                       input logic dok, input logic [3:0] src, input logic [DW-1:0] d);
    while (!iss_ready) @(negedge clk);
    iss_valid = 1'b1; iss_store = st; iss_addr = {8'h00, a}; iss_tag = tg;
    iss_data_ok = dok; iss_src_tag = src; iss_data = d;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [3:0] tg, input logic [DW-1:0] d);
    bc_valid = 1'b1; bc_tag = tg; bc_data = d;
    @(negedge clk);
    bc_valid = 1'b0;
  endtask

  // memory model with fixed latency
  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 32'hA000_0000 + i;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [7:0] a;
        logic w;
        logic [DW-1:0] wd;
        a = mem_req_addr[7:0]; w = mem_req_write; wd = mem_req_wdata;
        if (nreq < 64) begin
          log_addr[nreq] = mem_req_addr;
          log_wr[nreq]   = w;
        end
        nreq++;
        for (int c = 0; c < LAT - 1; c++) begin
          @(negedge clk);
          if (mem_req_valid) overlap++;
        end
        if (w) begin
          bmem[a] = wd;
          if (a == 8'd3) wr3++;
        end else begin
          mem_rdata = bmem[a];
          nrd++;
        end
        mem_done = 1'b1;
        @(negedge clk);
        if (mem_req_valid) overlap++;
        mem_done = 1'b0;
      end
    end
  end

  // result monitor (R9)
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid && !rst) begin
        chk(exp_set[res_tag] && res_data == exp_val[res_tag], "R9 result by tag",
            res_data, exp_val[res_tag]);
        got[res_tag]++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      ntest++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] sh [256];
    int base, rd0;
    bit allok;
    for (int i = 0; i < 256; i++) sh[i] = 32'hA000_0000 + i;
    for (int i = 0; i < 16; i++) begin exp_set[i] = 1'b0; got[i] = 0; exp_val[i] = '0; end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(iss_ready == 1'b1, "R10 iss_ready", DW'(iss_ready), 1);
    chk(mem_req_valid == 1'b0, "R10 mem_req_valid", DW'(mem_req_valid), 0);
    chk(res_valid == 1'b0, "R10 res_valid", DW'(res_valid), 0);

    // table: expectations follow program order through a shadow memory
    for (int v = 0; v < NV; v++) begin
      if (TBL[v][33]) sh[TBL[v][32:25]] = DW'(TBL[v][15:0]);
      else begin
        exp_val[TBL[v][24:21]] = sh[TBL[v][32:25]];
        exp_set[TBL[v][24:21]] = 1'b1;
      end
    end
    for (int v = 0; v < NV; v++)
      issue(TBL[v][33], TBL[v][32:25], TBL[v][24:21], TBL[v][20], TBL[v][19:16],
            DW'(TBL[v][15:0]));
    repeat (40) @(negedge clk);
    // R3: load past a store still waiting for data
    chk(got[1] == 1, "R3 bypass load returned", DW'(got[1]), 1);
    chk(got[4] == 1 && got[7] == 1, "R3 independent loads returned",
        DW'(got[4] + got[7]), 2);
    // R5: forwarded loads wait for their store's data
    chk(got[2] == 0 && got[5] == 0, "R5 waiting loads held", DW'(got[2] + got[5]), 0);
    bcast(4'd12, 32'h1111);
    bcast(4'd13, 32'h3333);
    repeat (40) @(negedge clk);
    allok = 1'b1;
    for (int t = 1; t <= 7; t++) if (got[t] != 1) allok = 1'b0;
    chk(allok, "R9 each table load once", DW'(allok), 1);
    chk(got[2] == 1 && got[5] == 1, "R5 waiting loads completed", DW'(got[2] + got[5]), 2);
    chk(bmem[6] == 32'h3333, "R2 store data from broadcast", bmem[6], 32'h3333);
    // R6: the replaced store at address 3 is never written
    chk(bmem[3] == 32'h4444, "R6 final value addr 3", bmem[3], 32'h4444);
    chk(wr3 == 1, "R6 single write to addr 3", DW'(wr3), 1);

    // R4: youngest of two matching stores, result one cycle after accept
    exp_val[8] = 32'h55; exp_set[8] = 1'b1;
    rd0 = nrd;
    issue(1'b1, 8'd20, 4'd0, 1'b1, 4'd0, 32'h11);
    issue(1'b1, 8'd20, 4'd0, 1'b1, 4'd0, 32'h55);
    issue(1'b0, 8'd20, 4'd8, 1'b0, 4'd0, 32'h0);
    @(negedge clk);
    chk(res_valid && res_tag == 4'd8 && res_data == 32'h55, "R4 forward timing/value",
        res_data, 32'h55);
    repeat (30) @(negedge clk);
    chk(nrd == rd0, "R4 no memory read", DW'(nrd), DW'(rd0));
    chk(bmem[20] == 32'h55, "R4 youngest store lands last", bmem[20], 32'h55);

    // R7: a ready load wins the port over an older ready store
    exp_val[9] = bmem[32]; exp_set[9] = 1'b1;
    base = nreq;
    issue(1'b1, 8'd30, 4'd0, 1'b1, 4'd0, 32'h77);
    issue(1'b1, 8'd31, 4'd0, 1'b1, 4'd0, 32'h88);
    issue(1'b0, 8'd32, 4'd9, 1'b0, 4'd0, 32'h0);
    repeat (30) @(negedge clk);
    chk(log_wr[base] == 1'b1 && log_addr[base] == 16'd30, "R7 first request",
        DW'(log_addr[base]), 30);
    chk(log_wr[base+1] == 1'b0 && log_addr[base+1] == 16'd32, "R7 load before store",
        DW'(log_addr[base+1]), 32);
    chk(log_wr[base+2] == 1'b1 && log_addr[base+2] == 16'd31, "R7 store after load",
        DW'(log_addr[base+2]), 31);

    // R1: fill with stores waiting for data
    for (int i = 0; i < DEPTH - 1; i++)
      issue(1'b1, 8'(40 + i), 4'd0, 1'b0, 4'd14, 32'h0);
    chk(iss_ready == 1'b1, "R1 ready at DEPTH-1", DW'(iss_ready), 1);
    issue(1'b1, 8'(40 + DEPTH - 1), 4'd0, 1'b0, 4'd14, 32'h0);
    chk(iss_ready == 1'b0, "R1 not ready when full", DW'(iss_ready), 0);
    repeat (5) @(negedge clk);
    chk(nreq == base + 3, "R2 no store sent without data", DW'(nreq), DW'(base + 3));
    bcast(4'd14, 32'hBEEF);
    repeat (60) @(negedge clk);
    chk(iss_ready == 1'b1, "R1 ready after drain", DW'(iss_ready), 1);
    allok = 1'b1;
    for (int i = 0; i < DEPTH; i++) if (bmem[40 + i] != 32'hBEEF) allok = 1'b0;
    chk(allok, "R2 all waiting stores written", DW'(allok), 1);
    chk(overlap == 0, "R8 one request at a time", DW'(overlap), 0);

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule